// File: doc/BRIEF.md
# Multiplexed Local Bus Cycle Sequencer

This block runs external bus cycles on a bus whose low address bits and data share one set of lines. An internal requester hands it one cycle at a time: a cycle code, a 20-bit address, write data, a byte/word flag, a flag marking a DMA or refresh source, a refresh flag and a lock flag. The sequencer puts the address on the shared lines and pulses the address latch strobe. It then moves to the data phase, where it drives the read or write strobe, the transceiver enable and the transceiver direction. For the whole cycle it presents a 3-bit status code and the byte-enable pair. A synchronous ready, an asynchronous ready and a chip-select completion signal decide when the cycle may end. An external master can take the bus through a hold request and acknowledge pair.

The state machine has six states. IDLE is the state where the bus is free and a request can be accepted. T1 is the address phase. T2 is the state where the strobe is asserted. T3 samples the ready inputs, and every clock spent in T3 beyond the first is a wait state. T4 removes the strobes. HOLD is the state where the bus has been given away. The transitions are: IDLE to HOLD when a hold request is present and the previous cycle was not locked, otherwise IDLE to T1 when a request is present. T1 always goes to T2, and T2 always goes to T3. T3 goes to T4 when ready is seen or the cycle is a halt, and otherwise stays in T3. T4 always goes to IDLE. HOLD goes to IDLE when the hold request drops.

Top module: `mux_bus_seq`

## Requirements
- R1: A cycle that is accepted in IDLE passes through T1, T2, T3 and T4 in that order. The cycle code is shown on the status outputs for T1, T2 and every T3 clock, which is at least three clocks. The address latch strobe is high for the single T1 clock.
- R2: Status codes are 000 interrupt acknowledge, 001 I/O read, 010 I/O write, 011 halt, 100 instruction fetch, 101 memory read, 110 memory write and 111 passive. The request's cycle code is shown unchanged on the status outputs.
- R3: The pair formed by shared-bus bit 0 in T1 and the active-low high-byte enable is 00 for a word, 01 for an even byte and 10 for an odd byte. A refresh cycle forces the pair to 11.
- R4: In T1 the shared bus drives address bits 15:1 together with the A0 value from R3, and the upper address outputs carry address bits 19:16. From T2 to T4 the upper outputs carry the source flag in bit 19, which is 1 for DMA or refresh, and 0 in bits 18:16.
- R5: Read-type cycles (codes 000, 001, 100, 101) hold the read strobe low in T2 and T3, release the shared bus, and enable the transceiver in T2 and T3 with direction 0 (receive). The data on the bus when T3 ends is presented in T4 together with a valid flag.
- R6: Write cycles (codes 010, 110) hold the write strobe low in T2 and T3, drive the write data on the shared bus from T2 to T4, enable the transceiver in T2 and T3, and hold direction 1 (transmit) for the whole cycle.
- R7: While no ready source is asserted, the cycle stays in T3. Each extra clock adds one wait state.
- R8: The asynchronous ready passes through SYNC_STAGES flops before it is used. A cycle ended by that input alone therefore spends SYNC_STAGES more T3 clocks than one ended by the synchronous ready.
- R9: The chip-select completion input ends T3 by itself, with both ready inputs low.
- R10: A halt cycle (011) drives neither strobe, does not enable the transceiver and leaves T3 after one clock without any ready input.
- R11: A hold request is granted only from IDLE. In HOLD the acknowledge and float outputs are high, the shared bus is released, the strobes are inactive, the status is 111 and no request is accepted.
- R12: After a cycle issued with the lock flag, a hold request is not granted until a cycle without the lock flag has completed.
- R13: After reset and in IDLE, the status is 111, the strobes, latch strobe and transceiver enable are inactive, and a request can be accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A cycle is requested |
| req_kind | input | 3 | Cycle code, using the R2 encoding |
| req_addr | input | 20 | Cycle address |
| req_wdata | input | 16 | Write data |
| req_byte | input | 1 | 1 = byte transfer, 0 = word transfer |
| req_alt_src | input | 1 | 1 = DMA-initiated cycle |
| req_refresh | input | 1 | 1 = refresh cycle |
| req_lock | input | 1 | 1 = locked cycle |
| req_ready | output | 1 | The request is accepted this clock |
| rdata | output | 16 | Data captured by a read-type cycle |
| rdata_valid | output | 1 | rdata is valid (T4 of a read-type cycle) |
| srdy | input | 1 | Synchronous ready |
| ardy | input | 1 | Asynchronous ready |
| cs_auto_done | input | 1 | Chip-select completion, ends T3 |
| hold_req | input | 1 | External master requests the bus |
| hold_ack | output | 1 | Bus handed over |
| bus_float | output | 1 | Bus and control outputs released |
| ad_out | output | 16 | Shared address/data value driven |
| ad_oe | output | 1 | Shared bus output enable |
| ad_in | input | 16 | Shared bus value read |
| a_hi | output | 4 | Upper address / source outputs |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| st | output | 3 | Cycle status code |
| bhe_n | output | 1 | High-byte enable, active low |
| den_n | output | 1 | Transceiver enable, active low |
| dtr | output | 1 | Transceiver direction, 1 = transmit |

## Verification
The bench builds the block with its default parameters: a 20-bit address, a 16-bit shared bus and two synchronizer stages on the asynchronous ready. At these values the upper address outputs split into one source bit and three zeroed bits, which can be checked bit by bit. The two-stage synchronizer shows up as exactly two extra T3 clocks when the asynchronous ready ends a cycle, so the directed tests can tell it apart from the synchronous and chip-select paths, and each of those paths is also run with counted wait states.

// File: rtl/mbs_pkg.sv
`timescale 1ns/1ps
package mbs_pkg;

    typedef enum logic [2:0] {
        CK_INTA    = 3'b000,
        CK_IORD    = 3'b001,
        CK_IOWR    = 3'b010,
        CK_HALT    = 3'b011,
        CK_FETCH   = 3'b100,
        CK_MEMRD   = 3'b101,
        CK_MEMWR   = 3'b110,
        CK_PASSIVE = 3'b111
    } cyc_kind_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_T1,
        PH_T2,
        PH_T3,
        PH_T4,
        PH_HOLD
    } phase_t;

    function automatic logic kind_writes(cyc_kind_t k);
        return (k == CK_IOWR) || (k == CK_MEMWR);
    endfunction

    function automatic logic kind_reads(cyc_kind_t k);
        return (k == CK_INTA) || (k == CK_IORD) || (k == CK_FETCH) || (k == CK_MEMRD);
    endfunction

endpackage

// File: rtl/mbs_ready_merge.sv
`timescale 1ns/1ps
module mbs_ready_merge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic srdy_i,
    input  logic ardy_i,
    input  logic cs_done_i,
    output logic go_o
);

    logic [SYNC_STAGES-1:0] chain;

    generate
        if (SYNC_STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= ardy_i;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[SYNC_STAGES-2:0], ardy_i};
            end
        end
    endgenerate

    // any one source may end the cycle
    assign go_o = srdy_i | chain[SYNC_STAGES-1] | cs_done_i;

endmodule

// File: rtl/mbs_cycle_fsm.sv
`timescale 1ns/1ps
module mbs_cycle_fsm
    import mbs_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    input  logic [2:0]        req_kind_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    input  logic              req_byte_i,
    input  logic              req_alt_i,
    input  logic              req_rfsh_i,
    input  logic              req_lock_i,
    output logic              req_ready_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rdata_valid_o,
    input  logic              go_i,
    input  logic              hold_req_i,
    output logic              hold_ack_o,
    output logic              bus_float_o,
    output logic [DATA_W-1:0] ad_out_o,
    output logic              ad_oe_o,
    input  logic [DATA_W-1:0] ad_in_i,
    output logic [ADDR_W-DATA_W-1:0] a_hi_o,
    output logic              ale_o,
    output logic              rd_n_o,
    output logic              wr_n_o,
    output logic [2:0]        st_o,
    output logic              bhe_n_o,
    output logic              den_n_o,
    output logic              dtr_o
);

    localparam int HI_W = ADDR_W - DATA_W;

    phase_t            phase, phase_nx;
    cyc_kind_t         kind_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              byte_q, alt_q, rfsh_q, lock_q;
    logic [DATA_W-1:0] rdata_q;

    logic grant_ok, accept, is_wr, is_rd, is_halt, a0_v, bhe_v, src_v;

    assign grant_ok = hold_req_i && !lock_q;
    assign accept   = (phase == PH_IDLE) && req_valid_i && !grant_ok;
    assign is_wr    = kind_writes(kind_q);
    assign is_rd    = kind_reads(kind_q);
    assign is_halt  = (kind_q == CK_HALT);
    assign a0_v     = rfsh_q | (byte_q & addr_q[0]);
    assign bhe_v    = rfsh_q | (byte_q & ~addr_q[0]);
    assign src_v    = alt_q | rfsh_q;

    // next-state decode
    always_comb begin
        phase_nx = phase;
        unique case (phase)
            PH_IDLE: begin
                if (grant_ok)         phase_nx = PH_HOLD;
                else if (req_valid_i) phase_nx = PH_T1;
            end
            PH_T1:   phase_nx = PH_T2;
            PH_T2:   phase_nx = PH_T3;
            PH_T3:   if (go_i || is_halt) phase_nx = PH_T4;
            PH_T4:   phase_nx = PH_IDLE;
            PH_HOLD: if (!hold_req_i) phase_nx = PH_IDLE;
            default: phase_nx = PH_IDLE;
        endcase
    end

    // state register and request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            kind_q  <= CK_PASSIVE;
            addr_q  <= '0;
            wdata_q <= '0;
            byte_q  <= 1'b0;
            alt_q   <= 1'b0;
            rfsh_q  <= 1'b0;
            lock_q  <= 1'b0;
            rdata_q <= '0;
        end else begin
            phase <= phase_nx;
            if (accept) begin
                kind_q  <= cyc_kind_t'(req_kind_i);
                addr_q  <= req_addr_i;
                wdata_q <= req_wdata_i;
                byte_q  <= req_byte_i;
                alt_q   <= req_alt_i;
                rfsh_q  <= req_rfsh_i;
                lock_q  <= req_lock_i;
            end
            if ((phase == PH_T3) && go_i && is_rd)
                rdata_q <= ad_in_i;
        end
    end

    // outputs decoded from the state
    always_comb begin
        req_ready_o   = 1'b0;
        hold_ack_o    = 1'b0;
        bus_float_o   = 1'b0;
        ad_out_o      = '0;
        ad_oe_o       = 1'b0;
        a_hi_o        = '0;
        ale_o         = 1'b0;
        rd_n_o        = 1'b1;
        wr_n_o        = 1'b1;
        st_o          = CK_PASSIVE;
        bhe_n_o       = 1'b1;
        den_n_o       = 1'b1;
        dtr_o         = 1'b0;
        rdata_valid_o = 1'b0;
        unique case (phase)
            PH_IDLE: begin
                req_ready_o = !grant_ok;
            end
            PH_T1: begin
                ale_o    = 1'b1;
                st_o     = kind_q;
                ad_oe_o  = 1'b1;
                ad_out_o = {addr_q[DATA_W-1:1], a0_v};
                a_hi_o   = addr_q[ADDR_W-1:DATA_W];
                bhe_n_o  = bhe_v;
                dtr_o    = is_wr;
            end
            PH_T2, PH_T3: begin
                st_o    = kind_q;
                a_hi_o  = {src_v, {(HI_W-1){1'b0}}};
                bhe_n_o = bhe_v;
                dtr_o   = is_wr;
                if (is_wr) begin
                    wr_n_o   = 1'b0;
                    den_n_o  = 1'b0;
                    ad_oe_o  = 1'b1;
                    ad_out_o = wdata_q;
                end else if (is_rd) begin
                    rd_n_o  = 1'b0;
                    den_n_o = 1'b0;
                end
            end
            PH_T4: begin
                a_hi_o        = {src_v, {(HI_W-1){1'b0}}};
                bhe_n_o       = bhe_v;
                dtr_o         = is_wr;
                rdata_valid_o = is_rd;
                if (is_wr) begin
                    ad_oe_o  = 1'b1;
                    ad_out_o = wdata_q;
                end
            end
            PH_HOLD: begin
                hold_ack_o  = 1'b1;
                bus_float_o = 1'b1;
            end
            default: ;
        endcase
    end

    assign rdata_o = rdata_q;

    // R1
    ale_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ale_o |=> !ale_o);

    // R13
    ale_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ale_o |-> ($past(st_o) == 3'b111));

    // R5
    rd_after_ale_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_n_o) |-> $past(ale_o));

    // R6
    wr_after_ale_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_n_o) |-> $past(ale_o));

    // R11
    grant_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_ack_o) |-> $past(hold_req_i));

    // R12
    grant_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_ack_o) |-> !$past(lock_q));

endmodule

// File: rtl/mux_bus_seq.sv
`timescale 1ns/1ps
module mux_bus_seq #(
    parameter int ADDR_W      = 20,
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_byte,
    input  logic              req_alt_src,
    input  logic              req_refresh,
    input  logic              req_lock,
    output logic              req_ready,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_valid,
    input  logic              srdy,
    input  logic              ardy,
    input  logic              cs_auto_done,
    input  logic              hold_req,
    output logic              hold_ack,
    output logic              bus_float,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    input  logic [DATA_W-1:0] ad_in,
    output logic [ADDR_W-DATA_W-1:0] a_hi,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n,
    output logic [2:0]        st,
    output logic              bhe_n,
    output logic              den_n,
    output logic              dtr
);

    logic go;

    mbs_ready_merge #(.SYNC_STAGES(SYNC_STAGES)) u_ready (
        .clk       (clk),
        .rst_n     (rst_n),
        .srdy_i    (srdy),
        .ardy_i    (ardy),
        .cs_done_i (cs_auto_done),
        .go_o      (go)
    );

    mbs_cycle_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid_i   (req_valid),
        .req_kind_i    (req_kind),
        .req_addr_i    (req_addr),
        .req_wdata_i   (req_wdata),
        .req_byte_i    (req_byte),
        .req_alt_i     (req_alt_src),
        .req_rfsh_i    (req_refresh),
        .req_lock_i    (req_lock),
        .req_ready_o   (req_ready),
        .rdata_o       (rdata),
        .rdata_valid_o (rdata_valid),
        .go_i          (go),
        .hold_req_i    (hold_req),
        .hold_ack_o    (hold_ack),
        .bus_float_o   (bus_float),
        .ad_out_o      (ad_out),
        .ad_oe_o       (ad_oe),
        .ad_in_i       (ad_in),
        .a_hi_o        (a_hi),
        .ale_o         (ale),
        .rd_n_o        (rd_n),
        .wr_n_o        (wr_n),
        .st_o          (st),
        .bhe_n_o       (bhe_n),
        .den_n_o       (den_n),
        .dtr_o         (dtr)
    );

endmodule

// File: tb/test_mux_bus_seq.sv
`timescale 1ns/1ps
module test_mux_bus_seq;

    localparam int SYNC = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_kind = 3'b111;
    logic [19:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        req_byte = 1'b0, req_alt_src = 1'b0, req_refresh = 1'b0, req_lock = 1'b0;
    logic        req_ready;
    logic [15:0] rdata;
    logic        rdata_valid;
    logic        srdy = 1'b0, ardy = 1'b0, cs_auto_done = 1'b0, hold_req = 1'b0;
    logic        hold_ack, bus_float, ad_oe, ale, rd_n, wr_n, bhe_n, den_n, dtr;
    logic [15:0] ad_out;
    logic [15:0] ad_in = '0;
    logic [3:0]  a_hi;
    logic [2:0]  st;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    mux_bus_seq #(.SYNC_STAGES(SYNC)) i_mux_bus_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_byte(req_byte),
        .req_alt_src(req_alt_src), .req_refresh(req_refresh), .req_lock(req_lock),
        .req_ready(req_ready), .rdata(rdata), .rdata_valid(rdata_valid),
        .srdy(srdy), .ardy(ardy), .cs_auto_done(cs_auto_done),
        .hold_req(hold_req), .hold_ack(hold_ack), .bus_float(bus_float),
        .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .a_hi(a_hi), .ale(ale),
        .rd_n(rd_n), .wr_n(wr_n), .st(st), .bhe_n(bhe_n), .den_n(den_n), .dtr(dtr)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // path: 0 srdy, 1 ardy, 2 chip-select completion, 3 no ready
    task automatic run_cycle(input string req, input logic [2:0] kind, input logic [19:0] addr,
                             input logic [15:0] wd, input logic byt, input logic alt,
                             input logic rf, input logic lk, input int wait_n, input int path,
                             input logic [15:0] din, input int exp_t3,
                             input logic exp_a0, input logic exp_bhe);
        logic wr = (kind == 3'b010) || (kind == 3'b110);
        logic rd = (kind == 3'b000) || (kind == 3'b001) || (kind == 3'b100) || (kind == 3'b101);
        int k;
        req_valid = 1'b1; req_kind = kind; req_addr = addr; req_wdata = wd;
        req_byte = byt; req_alt_src = alt; req_refresh = rf; req_lock = lk;
        chk(req, "accept", req_ready, 1);
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        // T1
        chk("R1", {req, " T1 ale"}, ale, 1);
        chk("R2", {req, " T1 status"}, st, kind);
        chk("R4", {req, " T1 bus"}, {ad_oe, ad_out[15:1]}, {1'b1, addr[15:1]});
        chk("R4", {req, " T1 upper"}, a_hi, addr[19:16]);
        chk("R3", {req, " A0/BHE pair"}, {ad_out[0], bhe_n}, {exp_a0, exp_bhe});
        @(posedge clk); @(negedge clk);
        // T2
        chk("R1", {req, " T2 ale low"}, ale, 0);
        chk("R4", {req, " T2 upper"}, a_hi, {alt | rf, 3'b000});
        chk("R5", {req, " T2 rd_n"}, rd_n, !rd);
        chk("R6", {req, " T2 wr_n"}, wr_n, !wr);
        chk("R10", {req, " T2 den_n"}, den_n, !(rd || wr));
        chk("R6", {req, " T2 dtr"}, dtr, wr);
        if (wr) chk("R6", {req, " T2 data"}, {ad_oe, ad_out}, {1'b1, wd});
        else    chk("R5", {req, " T2 bus released"}, ad_oe, 0);
        @(posedge clk); @(negedge clk);
        // T3 and wait states
        k = 0;
        while (st == kind && k < 40) begin
            chk("R7", {req, " T3 strobe"}, {rd_n, wr_n}, {!rd, !wr});
            if (k == wait_n) begin
                if (path == 0) srdy = 1'b1;
                if (path == 1) ardy = 1'b1;
                if (path == 2) cs_auto_done = 1'b1;
            end
            ad_in = din;
            @(posedge clk); @(negedge clk);
            k++;
        end
        chk(path == 1 ? "R8" : (path == 2 ? "R9" : (path == 3 ? "R10" : "R7")),
            {req, " T3 clocks"}, k, exp_t3);
        srdy = 1'b0; ardy = 1'b0; cs_auto_done = 1'b0;
        // T4
        chk("R1", {req, " T4 status passive"}, st, 3'b111);
        chk("R5", {req, " T4 strobes off"}, {rd_n, wr_n, den_n}, 3'b111);
        if (rd) chk("R5", {req, " read data"}, {rdata_valid, rdata}, {1'b1, din});
        if (wr) chk("R6", {req, " T4 data held"}, {ad_oe, ad_out, dtr}, {1'b1, wd, 1'b1});
        ad_in = '0;
        @(posedge clk); @(negedge clk);
        chk("R13", {req, " back to idle"}, {st, ale, rd_n, wr_n, den_n}, {3'b111, 1'b0, 3'b111});
    endtask

    task automatic t_reset();
        chk("R13", "reset outputs", {st, ale, rd_n, wr_n, den_n, hold_ack, ad_oe},
            {3'b111, 1'b0, 3'b111, 1'b0, 1'b0});
        chk("R13", "reset accepts", req_ready, 1);
    endtask

    task automatic t_hold();
        hold_req = 1'b1; req_valid = 1'b1; req_kind = 3'b101;
        @(posedge clk); @(negedge clk);
        chk("R11", "hold granted", {hold_ack, bus_float}, 2'b11);
        chk("R11", "hold released bus", {ad_oe, rd_n, wr_n, st, req_ready}, {1'b0, 1'b1, 1'b1, 3'b111, 1'b0});
        repeat (2) begin @(posedge clk); @(negedge clk); end
        chk("R11", "no cycle during hold", {ale, hold_ack}, 2'b01);
        hold_req = 1'b0; req_valid = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R11", "hold dropped", hold_ack, 0);
    endtask

    task automatic t_lock();
        run_cycle("R12 locked", 3'b101, 20'h12340, 16'h0, 1'b0, 1'b0, 1'b0, 1'b1, 0, 0, 16'h1111, 1, 1'b0, 1'b0);
        hold_req = 1'b1;
        repeat (3) begin @(posedge clk); @(negedge clk); end
        chk("R12", "hold deferred after lock", hold_ack, 0);
        run_cycle("R12 unlocked", 3'b101, 20'h12342, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, 0, 0, 16'h2222, 1, 1'b0, 1'b0);
        @(posedge clk); @(negedge clk);
        chk("R12", "hold after unlocked cycle", hold_ack, 1);
        hold_req = 1'b0;
        @(posedge clk); @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        // memory read, word, synchronous ready, no waits
        run_cycle("R2 memrd", 3'b101, 20'h5A3C4, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, 0, 0, 16'hBEEF, 1, 1'b0, 1'b0);
        // I/O write, even byte, two wait states
        run_cycle("R7 iowr", 3'b010, 20'h01236, 16'hA55A, 1'b1, 1'b0, 1'b0, 1'b0, 2, 0, 16'h0, 3, 1'b0, 1'b1);
        // fetch, odd byte, asynchronous ready
        run_cycle("R8 fetch", 3'b100, 20'h7FFF1, 16'h0, 1'b1, 1'b0, 1'b0, 1'b0, 0, 1, 16'h3C3C, 1 + SYNC, 1'b1, 1'b0);
        // DMA memory write, chip-select completion after one wait
        run_cycle("R9 memwr", 3'b110, 20'hC0010, 16'h5678, 1'b0, 1'b1, 1'b0, 1'b0, 1, 2, 16'h0, 2, 1'b0, 1'b0);
        // refresh
        run_cycle("R3 refresh", 3'b101, 20'h4E2A6, 16'h0, 1'b0, 1'b0, 1'b1, 1'b0, 0, 0, 16'h0F0F, 1, 1'b1, 1'b1);
        // halt, no ready
        run_cycle("R10 halt", 3'b011, 20'h00000, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, 0, 3, 16'h0, 1, 1'b0, 1'b0);
        // interrupt acknowledge
        run_cycle("R2 inta", 3'b000, 20'h00000, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, 0, 0, 16'h0042, 1, 1'b0, 1'b0);
        // I/O read, one wait
        run_cycle("R7 iord", 3'b001, 20'h000F8, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1, 0, 16'h9876, 2, 1'b0, 1'b0);
        t_hold();
        t_lock();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule